// File: doc/BRIEF.md
# Serial port status flag register

This block holds the status word of a serial transceiver. A register bus reads it as one 32-bit word and writes it with one strobe. Ten flags sit in the low bits. Six of them copy level signals that the transceiver core already holds: the three receive error kinds, overrun, line idle and transmit-buffer-empty. The other four are sticky. They are set by event pulses (receive data ready, transmit complete, line break seen) or by a change on the active-low clear-to-send pin. Software clears a sticky flag by writing zero to its bit. A single interrupt request is the OR of every flag that has an enable bit, each gated by that enable.

The clear-to-send pin is asynchronous. It passes through a synchronizer chain, and a three-state machine then watches it. In `CE_OFF` it ignores the pin while the watch enable is low. On the first enabled cycle, `CE_OFF -> CE_PRIME`. `CE_PRIME` captures the synchronized level as a reference and raises no event, and `CE_PRIME -> CE_WATCH` follows on the next cycle if the enable is still high. In `CE_WATCH` any difference between the synchronized level and the reference gives a one-cycle toggle event and updates the reference. From every state, a low enable returns the machine to `CE_OFF` (`CE_PRIME -> CE_OFF`, `CE_WATCH -> CE_OFF`). Reset puts the machine in `CE_OFF` and fills the synchronizer with the idle level 1.

Top module: `sio_status_reg`

## Requirements
- R1: Flag bit positions are PE 0, FE 1, NE 2, ORE 3, IDLE 4, RXNE 5, TC 6, TXE 7, LBD 8, CTS 9. Bits 31:10 always read 0.
- R2: After reset the word reads 0x000000C0 (TC and TXE set), and the request line is low.
- R3: PE, FE, NE, ORE, IDLE and TXE show the level that `st_perr`, `st_ferr`, `st_nerr`, `st_ovrun`, `st_idle` and `st_txempty` had at the previous clock edge. Bus writes never change them.
- R4: A one-cycle pulse on `ev_rxdone` sets RXNE, and a pulse on `ev_txdone` sets TC, on the next edge. Each flag then stays set until it is cleared.
- R5: A write with a 0 in bit 9, 8, 6 or 5 clears that flag on the edge of the write. A 1 in those bits leaves the flag unchanged. Writes to all other bits are ignored.
- R6: When a set event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R7: A pulse on `ev_break` sets LBD on the next edge.
- R8: While `cts_en` is high, a level change on `cts_n` in either direction sets CTS on the third rising edge after the change (two synchronizer stages plus the flag register).
- R9: With `cts_en` low, changes on `cts_n` never set CTS. The first synchronized sample after reset, or after `cts_en` rises, is only a reference and never counts as a change.
- R10: `irq` is high exactly when a flag is set together with its bit in `int_en` (same positions as R1). Only CTS, LBD, TXE, TC, RXNE, IDLE and PE take part. `int_en` bits 1 to 3 have no effect. `irq` follows flag and enable changes within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data (0 in a sticky bit clears it) |
| reg_rdata | output | 32 | Current status word |
| st_perr | input | 1 | Parity error level from core |
| st_ferr | input | 1 | Framing error level from core |
| st_nerr | input | 1 | Noise error level from core |
| st_ovrun | input | 1 | Overrun level from core |
| st_idle | input | 1 | Idle-line level from core |
| st_txempty | input | 1 | Transmit buffer empty level from core |
| ev_rxdone | input | 1 | Pulse: received word available |
| ev_txdone | input | 1 | Pulse: transmission complete |
| ev_break | input | 1 | Pulse: line break detected |
| cts_n | input | 1 | Asynchronous clear-to-send pin, active low |
| cts_en | input | 1 | Enables change detection on cts_n |
| int_en | input | 10 | Per-flag interrupt enables, flag bit positions |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check these rules on every cycle:
- a set event always lands in its sticky flag, even against a clearing write;
- a zero write clears and a one write holds;
- each level-copied flag follows its input with one cycle of delay;
- the edge watcher drops to `CE_OFF` whenever disabled, and raises no event in `CE_OFF` or `CE_PRIME`;
- a request is never raised without an enabled flag behind it.

The exact three-edge latency of a clear-to-send change needs the bench scenarios. So do the absence of a spurious event after re-enabling on a moved pin, the reset word, and the masked enable bits. The bench covers them with directed steps, and a random phase is compared against its own reference model on every clock.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
    localparam int NFLAG  = 10;
    localparam int F_PE   = 0;
    localparam int F_FE   = 1;
    localparam int F_NE   = 2;
    localparam int F_ORE  = 3;
    localparam int F_IDLE = 4;
    localparam int F_RXNE = 5;
    localparam int F_TC   = 6;
    localparam int F_TXE  = 7;
    localparam int F_LBD  = 8;
    localparam int F_CTS  = 9;

    // sticky, write-zero-to-clear flags
    localparam logic [NFLAG-1:0] STICKY_MASK =
        (10'd1 << F_CTS) | (10'd1 << F_LBD) | (10'd1 << F_TC) | (10'd1 << F_RXNE);
    localparam logic [NFLAG-1:0] RESET_FLAGS =
        (10'd1 << F_TXE) | (10'd1 << F_TC);
    localparam logic [NFLAG-1:0] IRQ_SRC_MASK =
        (10'd1 << F_CTS) | (10'd1 << F_LBD) | (10'd1 << F_TXE) | (10'd1 << F_TC) |
        (10'd1 << F_RXNE) | (10'd1 << F_IDLE) | (10'd1 << F_PE);

    typedef enum logic [1:0] {
        CE_OFF   = 2'd0,
        CE_PRIME = 2'd1,
        CE_WATCH = 2'd2
    } cts_state_t;
endpackage

// File: rtl/sio_sync_chain.sv
module sio_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_LEVEL;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_LEVEL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sio_cts_watch.sv
module sio_cts_watch
    import sio_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic watch_en,
    input  logic lvl_sync,
    output logic toggle
);
    cts_state_t state_q, state_d;
    logic       ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        toggle  = 1'b0;
        unique case (state_q)
            CE_OFF:   if (watch_en) state_d = CE_PRIME;
            CE_PRIME: state_d = watch_en ? CE_WATCH : CE_OFF;
            CE_WATCH: begin
                if (!watch_en) state_d = CE_OFF;
                else           toggle  = (lvl_sync != ref_q);
            end
            default:  state_d = CE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                ref_q <= 1'b1;
        else if (state_q == CE_PRIME || toggle)    ref_q <= lvl_sync;
    end

    assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !watch_en |=> (state_q == CE_OFF));
    assert_prime_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CE_WATCH) |-> !toggle);
endmodule

// File: rtl/sio_flag_bank.sv
module sio_flag_bank #(
    parameter int                NF       = 10,
    parameter logic [NF-1:0]     STICKY   = '0,
    parameter logic [NF-1:0]     RST_VAL  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] lvl_in,
    input  logic [NF-1:0] set_pls,
    input  logic          wr_en,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] flag_q
);
    logic unused_bank;
    assign unused_bank = ^(lvl_in & STICKY) ^ ^(set_pls & ~STICKY) ^ ^(wdata & ~STICKY);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        if (STICKY[i]) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  flag_q[i] <= RST_VAL[i];
                else if (set_pls[i])         flag_q[i] <= 1'b1;
                else if (wr_en && !wdata[i]) flag_q[i] <= 1'b0;
            end

            assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
                set_pls[i] |=> flag_q[i]);
            assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wdata[i] && !set_pls[i]) |=> !flag_q[i]);
            assert_one_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[i] && !(wr_en && !wdata[i])) |=> flag_q[i]);
        end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flag_q[i] <= RST_VAL[i];
                else        flag_q[i] <= lvl_in[i];
            end

            assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (flag_q[i] == $past(lvl_in[i])));
        end
    end
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge #(
    parameter int            NF   = 10,
    parameter logic [NF-1:0] SRC  = '1
) (
    input  logic [NF-1:0] flags,
    input  logic [NF-1:0] ien,
    output logic          irq
);
    logic unused_ien;
    assign unused_ien = ^(ien & ~SRC);
    assign irq = |(flags & ien & SRC);
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
    import sio_stat_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              st_perr,
    input  logic              st_ferr,
    input  logic              st_nerr,
    input  logic              st_ovrun,
    input  logic              st_idle,
    input  logic              st_txempty,
    input  logic              ev_rxdone,
    input  logic              ev_txdone,
    input  logic              ev_break,
    input  logic              cts_n,
    input  logic              cts_en,
    input  logic [NFLAG-1:0]  int_en,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NFLAG;

    logic             cts_sync, cts_toggle;
    logic [NFLAG-1:0] lvl_vec, set_vec, flags;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NFLAG];

    sio_sync_chain #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cts_n), .q_sync(cts_sync)
    );

    sio_cts_watch u_watch (
        .clk(clk), .rst_n(rst_n), .watch_en(cts_en), .lvl_sync(cts_sync), .toggle(cts_toggle)
    );

    always_comb begin
        lvl_vec         = '0;
        lvl_vec[F_PE]   = st_perr;
        lvl_vec[F_FE]   = st_ferr;
        lvl_vec[F_NE]   = st_nerr;
        lvl_vec[F_ORE]  = st_ovrun;
        lvl_vec[F_IDLE] = st_idle;
        lvl_vec[F_TXE]  = st_txempty;
        set_vec         = '0;
        set_vec[F_RXNE] = ev_rxdone;
        set_vec[F_TC]   = ev_txdone;
        set_vec[F_LBD]  = ev_break;
        set_vec[F_CTS]  = cts_toggle;
    end

    sio_flag_bank #(.NF(NFLAG), .STICKY(STICKY_MASK), .RST_VAL(RESET_FLAGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_vec), .set_pls(set_vec),
        .wr_en(reg_wr), .wdata(reg_wdata[NFLAG-1:0]), .flag_q(flags)
    );

    sio_irq_merge #(.NF(NFLAG), .SRC(IRQ_SRC_MASK)) u_irq (
        .flags(flags), .ien(int_en), .irq(irq)
    );

    assign reg_rdata = {{PAD_W{1'b0}}, flags};

    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((reg_rdata[NFLAG-1:0] & int_en) != '0));
    assert_break_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_break |=> reg_rdata[F_LBD]);
endmodule

// File: tb/sio_status_reg_test.sv
`timescale 1ns/1ps
module sio_status_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        st_perr = 0, st_ferr = 0, st_nerr = 0, st_ovrun = 0, st_idle = 0, st_txempty = 0;
    logic        ev_rxdone = 0, ev_txdone = 0, ev_break = 0;
    logic        cts_n = 1'b1, cts_en = 1'b0;
    logic [9:0]  int_en = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sio_status_reg uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_perr(st_perr), .st_ferr(st_ferr), .st_nerr(st_nerr), .st_ovrun(st_ovrun),
        .st_idle(st_idle), .st_txempty(st_txempty), .ev_rxdone(ev_rxdone), .ev_txdone(ev_txdone),
        .ev_break(ev_break), .cts_n(cts_n), .cts_en(cts_en), .int_en(int_en), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_flag [10];
    bit m_hist [$];
    int m_mode;
    bit m_ref;

    task automatic model_reset();
        foreach (m_flag[k]) m_flag[k] = 0;
        m_flag[6] = 1;
        m_flag[7] = 1;
        m_hist = {1'b1, 1'b1};
        m_mode = 0;
        m_ref = 1;
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        for (int k = 0; k < 10; k++) w[k] = m_flag[k];
        return w;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit old_lvl, tog;
            bit [9:0] clr;
            old_lvl = m_hist[1];
            tog = (m_mode == 2) && cts_en && (old_lvl != m_ref);
            clr = reg_wr ? ~reg_wdata[9:0] : 10'd0;
            m_flag[9] = tog       | (m_flag[9] & !clr[9]);
            m_flag[8] = ev_break  | (m_flag[8] & !clr[8]);
            m_flag[6] = ev_txdone | (m_flag[6] & !clr[6]);
            m_flag[5] = ev_rxdone | (m_flag[5] & !clr[5]);
            m_flag[0] = st_perr;
            m_flag[1] = st_ferr;
            m_flag[2] = st_nerr;
            m_flag[3] = st_ovrun;
            m_flag[4] = st_idle;
            m_flag[7] = st_txempty;
            if (!cts_en) m_mode = 0;
            else if (m_mode == 0) m_mode = 1;
            else if (m_mode == 1) begin m_ref = old_lvl; m_mode = 2; end
            else if (tog) m_ref = old_lvl;
            m_hist.push_front(cts_n);
            void'(m_hist.pop_back());
        end
        #1;
        if (cmp_on) begin
            logic [31:0] mw;
            logic        mirq;
            mw = model_word();
            mirq = |(mw[9:0] & int_en & 10'h3F1);
            chk("R1 reserved",     {22'd0, reg_rdata[31:10]}, 32'd0);
            chk("R3 level flags",  {reg_rdata[7], reg_rdata[4:0]}, {mw[7], mw[4:0]});
            chk("R4 rxne/tc",      reg_rdata[6:5], mw[6:5]);
            chk("R7 lbd",          reg_rdata[8], mw[8]);
            chk("R8 cts",          reg_rdata[9], mw[9]);
            chk("R10 irq",         irq, mirq);
        end
    end

    // ---------------- watchdog ----------------
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 50000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step_chk(string req, logic [31:0] exp);
        @(negedge clk);
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        @(negedge clk);
        chk("R2 reset word", reg_rdata, 32'h0000_00C0);
        chk("R2 reset irq", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        st_txempty = 1'b1;
        cmp_on = 1;
        step_chk("R2 after release", 32'h0C0);

        // R3: level flags follow the core, writes do not touch them
        st_perr = 1; st_idle = 1;
        step_chk("R3 level copy", 32'h0D1);
        reg_wr = 1; reg_wdata = 32'h0;
        step_chk("R3/R5 zero write clears TC only", 32'h091);
        reg_wr = 0; st_perr = 0; st_idle = 0;
        step_chk("R3 level drop", 32'h080);

        // R4, R7: event pulses set sticky flags
        ev_rxdone = 1; ev_break = 1;
        step_chk("R4/R7 set", 32'h1A0);
        ev_rxdone = 0; ev_break = 0;
        step_chk("R4 sticky", 32'h1A0);

        // R5: ones hold, a single zero clears its bit
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
        step_chk("R5 ones hold, R1 upper zero", 32'h1A0);
        reg_wdata = ~32'h100;
        step_chk("R5 clear LBD", 32'h0A0);
        reg_wr = 0;

        // R6: set beats clear
        ev_rxdone = 1; reg_wr = 1; reg_wdata = 32'h0;
        step_chk("R6 set wins", 32'h0A0);
        ev_rxdone = 0; reg_wr = 0;

        // R9/R8: enable, prime without event, then falling and rising edges
        cts_en = 1;
        repeat (4) step_chk("R9 no event after enable", 32'h0A0);
        cts_n = 0;
        step_chk("R8 edge 1", 32'h0A0);
        step_chk("R8 edge 2", 32'h0A0);
        step_chk("R8 falling sets", 32'h2A0);
        reg_wr = 1; reg_wdata = ~32'h200;
        step_chk("R5 clear CTS", 32'h0A0);
        reg_wr = 0; cts_n = 1;
        step_chk("R8 edge 1 rise", 32'h0A0);
        step_chk("R8 edge 2 rise", 32'h0A0);
        step_chk("R8 rising sets", 32'h2A0);

        // R10: enables
        int_en = 10'h200;
        @(negedge clk); chk("R10 cts enabled", irq, 1'b1);
        int_en = 10'h00E; st_ferr = 1; reg_wr = 1; reg_wdata = ~32'h200;
        @(negedge clk);
        chk("R10 FE set", reg_rdata, 32'h0A2);
        chk("R10 masked enables", irq, 1'b0);
        reg_wr = 0; int_en = 10'h080;
        @(negedge clk); chk("R10 txe enabled", irq, 1'b1);
        int_en = 10'h000; st_ferr = 0;

        // R9: disabled watcher ignores the pin, re-enable on moved pin is silent
        cts_en = 0;
        step_chk("R9 disable", 32'h0A0);
        cts_n = 0; step_chk("R9 off toggle a", 32'h0A0);
        cts_n = 1; step_chk("R9 off toggle b", 32'h0A0);
        cts_n = 0; step_chk("R9 off toggle c", 32'h0A0);
        repeat (3) step_chk("R9 off settle", 32'h0A0);
        cts_en = 1;
        repeat (6) step_chk("R9 re-enable silent", 32'h0A0);

        // random phase, compared against the model each clock
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            st_perr    = $urandom_range(0, 1);
            st_ferr    = $urandom_range(0, 1);
            st_nerr    = $urandom_range(0, 1);
            st_ovrun   = $urandom_range(0, 1);
            st_idle    = $urandom_range(0, 1);
            st_txempty = $urandom_range(0, 1);
            ev_rxdone  = ($urandom_range(0, 3) == 0);
            ev_txdone  = ($urandom_range(0, 3) == 0);
            ev_break   = ($urandom_range(0, 5) == 0);
            reg_wr     = ($urandom_range(0, 4) == 0);
            reg_wdata  = $urandom;
            if ($urandom_range(0, 5) == 0)  cts_n  = ~cts_n;
            if ($urandom_range(0, 24) == 0) cts_en = ~cts_en;
            if ($urandom_range(0, 7) == 0)  int_en = 10'($urandom);
        end
        @(negedge clk);
        reg_wr = 0; ev_rxdone = 0; ev_txdone = 0; ev_break = 0;
        repeat (3) @(negedge clk);
        cmp_on = 0;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule